// File: doc/BRIEF.md
# Key-Protected Controller Register Bank

This block is the configuration register file of a DRAM controller. It is reached through a word-wide read/write request port. A 12-bit byte address covers a 4 KiB window, and the word index is the address with its two low bits dropped. Every request is accepted in the cycle it is presented. Its response appears one cycle later.

A protection word at index 0 gates most of the bank, using three states:

- **Soft locked:** the state after reset.
- **Open:** entered by writing the unlock key.
- **Hard locked:** entered by writing the hard key, and left only through reset.

Eight offsets form a whitelist and stay writable in every state. A blocked write raises a one-cycle `wr_blocked` flag alongside its response.

Three registers reshape what is written to them:

- **Configuration word:** keeps read-only fields and always reports the strapped DRAM size.
- **PHY status word:** never reports busy and always reports PLL lock.
- **Test-control word:** always reports a finished, passing test.

A few PHY words come out of reset holding "all good" values. This lets boot software find the memory already calibrated.

Top module: `kp_ctrl_regbank`

## Requirements
- R1: A write to byte offset 0x000 makes the protection word read 0x01 if the data is 0xFC600309, 0x10 if it is 0xDEADDEAD, and 0x00 for any other value, provided the bank is not hard locked.
- R2: After reset every implemented word reads 0, except as follows. The protection word reads 0x00. The configuration word (offset 0x004) reads 0x3000000C with bits 1:0 equal to `strap_size`. Offset 0x400 reads 0x00000002. Offset 0x450 reads 0x0FFFFFFF. Offsets 0x468 and 0x47C read 0x000000FF.
- R3: While hard locked, every write to a protected offset is blocked, including writes to offset 0x000 with either key, and the protection word keeps reading 0x10 until reset.
- R4: While soft locked, writes to protected offsets other than 0x000 are blocked and leave the word unchanged.
- R5: Writes to offsets 0x050, 0x06C, 0x074, 0x078, 0x07C, 0x088, 0x08C and 0x0B4 store the data unchanged in every lock state and are never blocked.
- R6: A write D to the configuration word stores (D & 0x0FF03FB0) | 0x3000000C. Bits 1:0 always read the current `strap_size`.
- R7: A write D to offset 0x060 stores D with bit 0 cleared and bit 4 set.
- R8: A write D to offset 0x070 stores D with bit 12 set and bit 13 cleared.
- R9: A read with word index at or above REG_WORDS (512 by default) returns 0. A write there changes no word and is not flagged as blocked.
- R10: `req_ready` is always 1. `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and only then.
- R11: `wr_blocked` is high exactly in the response cycle of a blocked write. It is low for accepted writes and for reads.
- R12: While open, any other in-range word stores the written data unchanged. Address bits 1:0 do not affect which word is accessed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_size | input | 2 | DRAM size index (0=256 MiB, 1=512 MiB, 2=1 GiB, 3=2 GiB) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the window |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| wr_blocked | output | 1 | The write of this response was refused by the lock |

## Verification
A wrong lock state shows up on the very next write to a protected word. `wr_blocked` then pulses when it should not, or the reverse, and the next read of that word returns stale or unexpected data. A key that is decoded wrongly shows on the following read of offset 0x000. A wrong write transform or reset value stays hidden until the affected word is read back. For that reason the bench reads back the whole implemented array after each write sweep in each lock state, so any such fault is seen within one sweep.

// File: rtl/kp_regbank_pkg.sv
package kp_regbank_pkg;

    typedef enum logic [1:0] {
        LK_SOFT = 2'd0,
        LK_OPEN = 2'd1,
        LK_HARD = 2'd2
    } lock_e;

    localparam logic [31:0] KEY_OPEN  = 32'hFC60_0309;
    localparam logic [31:0] KEY_HARD  = 32'hDEAD_DEAD;

    localparam logic [31:0] CODE_SOFT = 32'h0000_0000;
    localparam logic [31:0] CODE_OPEN = 32'h0000_0001;
    localparam logic [31:0] CODE_HARD = 32'h0000_0010;

    // word indices (byte offset / 4)
    localparam int unsigned IX_PROT    = 0;
    localparam int unsigned IX_CONF    = 1;
    localparam int unsigned IX_PHYSTAT = 24;    // 0x060
    localparam int unsigned IX_TESTCTL = 28;    // 0x070
    localparam int unsigned IX_PHYOK   = 256;   // 0x400
    localparam int unsigned IX_EYE_W   = 276;   // 0x450
    localparam int unsigned IX_EYE_A   = 282;   // 0x468
    localparam int unsigned IX_EYE_B   = 287;   // 0x47C
    localparam int unsigned IX_MIN_WORDS = IX_EYE_B + 1;

    // configuration word fields
    localparam logic [31:0] CF_VER_FIELD = 32'hF000_0000;
    localparam logic [31:0] CF_VER_VALUE = 32'h3000_0000;
    localparam logic [31:0] CF_FIX19     = 32'h0008_0000;
    localparam logic [31:0] CF_RSVD      = 32'h0007_C000;
    localparam logic [31:0] CF_FIX6      = 32'h0000_0040;
    localparam logic [31:0] CF_APERTURE  = 32'h0000_000C;
    localparam logic [31:0] CF_SIZE      = 32'h0000_0003;
    localparam logic [31:0] CF_RO_MASK   = CF_VER_FIELD | CF_FIX19 | CF_RSVD |
                                           CF_FIX6 | CF_APERTURE | CF_SIZE;
    localparam logic [31:0] CF_FIXED     = CF_VER_VALUE | CF_APERTURE;

    // PHY status / test control forced bits
    localparam logic [31:0] PS_BUSY      = 32'h0000_0001;
    localparam logic [31:0] PS_PLL_LOCK  = 32'h0000_0010;
    localparam logic [31:0] TC_DONE      = 32'h0000_1000;
    localparam logic [31:0] TC_FAIL      = 32'h0000_2000;

    typedef struct packed {
        logic        valid;
        logic        blocked;
        logic [31:0] rdata;
    } rsp_s;

    function automatic logic is_open_idx(input int unsigned ix);
        case (ix)
            20, 27, 29, 30, 31, 34, 35, 45: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] reset_word(input int unsigned ix);
        case (ix)
            IX_CONF:  return CF_FIXED;
            IX_PHYOK: return 32'h0000_0002;
            IX_EYE_W: return 32'h0FFF_FFFF;
            IX_EYE_A: return 32'h0000_00FF;
            IX_EYE_B: return 32'h0000_00FF;
            default:  return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/kp_lock_ctrl.sv
module kp_lock_ctrl
    import kp_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output lock_e       state,
    output logic [31:0] code
);

    typedef struct packed {
        lock_e st;
    } lock_s;

    lock_s lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (wr_en && lk_q.st != LK_HARD) begin
            if (wdata == KEY_OPEN)      lk_d.st = LK_OPEN;
            else if (wdata == KEY_HARD) lk_d.st = LK_HARD;
            else                        lk_d.st = LK_SOFT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{st: LK_SOFT};
        else        lk_q <= lk_d;
    end

    assign state = lk_q.st;

    always_comb begin
        case (lk_q.st)
            LK_OPEN: code = CODE_OPEN;
            LK_HARD: code = CODE_HARD;
            default: code = CODE_SOFT;
        endcase
    end

    // R3
    hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q.st == LK_HARD) |=> (lk_q.st == LK_HARD));

    // R1
    key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == KEY_OPEN && lk_q.st != LK_HARD) |=> (code == CODE_OPEN));

endmodule

// File: rtl/kp_write_shaper.sv
module kp_write_shaper
    import kp_regbank_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      shaped
);

    localparam logic [IDX_W-1:0] I_CONF = IDX_W'(IX_CONF);
    localparam logic [IDX_W-1:0] I_STAT = IDX_W'(IX_PHYSTAT);
    localparam logic [IDX_W-1:0] I_TEST = IDX_W'(IX_TESTCTL);

    always_comb begin
        if (idx == I_CONF)
            // size bits are dropped here and inserted live on read
            shaped = (wdata & ~CF_RO_MASK) | CF_FIXED;
        else if (idx == I_STAT)
            shaped = (wdata & ~PS_BUSY) | PS_PLL_LOCK;
        else if (idx == I_TEST)
            shaped = (wdata | TC_DONE) & ~TC_FAIL;
        else
            shaped = wdata;
    end

endmodule

// File: rtl/kp_reg_store.sv
module kp_reg_store
    import kp_regbank_pkg::*;
#(
    parameter int REG_WORDS = 512,
    parameter int STORE_W   = $clog2(REG_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [STORE_W-1:0] widx,
    input  logic [31:0]        wdata,
    input  logic [STORE_W-1:0] ridx,
    output logic [31:0]        rdata
);

    logic [31:0] mem_d [REG_WORDS];
    logic [31:0] mem_q [REG_WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_WORDS; i++) mem_q[i] <= reset_word(i);
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[ridx];

    // R7
    phystat_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx == STORE_W'(IX_PHYSTAT)) |=>
            (mem_q[IX_PHYSTAT][0] == 1'b0 && mem_q[IX_PHYSTAT][4] == 1'b1));

    // R8
    testctl_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx == STORE_W'(IX_TESTCTL)) |=>
            (mem_q[IX_TESTCTL][12] == 1'b1 && mem_q[IX_TESTCTL][13] == 1'b0));

endmodule

// File: rtl/kp_ctrl_regbank.sv
module kp_ctrl_regbank
    import kp_regbank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int REG_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_size,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              wr_blocked
);

    localparam int IDX_W   = ADDR_W - 2;
    localparam int STORE_W = $clog2(REG_WORDS);
    localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(REG_WORDS);

    logic [IDX_W-1:0]   idx;
    logic               unused_lsb;
    logic               in_range, is_prot, is_open, is_conf;
    logic               wr_req, allowed, store_we, lock_we, blocked;
    logic [31:0]        shaped, store_rd, lock_code, rd_val;
    logic [STORE_W-1:0] sidx;
    lock_e              lock_st;
    rsp_s               st_d, st_q;

    assign idx        = req_addr[ADDR_W-1:2];
    assign unused_lsb = ^req_addr[1:0];
    assign sidx       = idx[STORE_W-1:0];

    kp_lock_ctrl u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (lock_we),
        .wdata (req_wdata),
        .state (lock_st),
        .code  (lock_code)
    );

    kp_write_shaper #(.IDX_W(IDX_W)) u_shape (
        .idx    (idx),
        .wdata  (req_wdata),
        .shaped (shaped)
    );

    kp_reg_store #(.REG_WORDS(REG_WORDS), .STORE_W(STORE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .widx  (sidx),
        .wdata (shaped),
        .ridx  (sidx),
        .rdata (store_rd)
    );

    always_comb begin
        in_range = ({1'b0, idx} < LIMIT);
        is_prot  = (idx == IDX_W'(IX_PROT));
        is_conf  = (idx == IDX_W'(IX_CONF));
        is_open  = is_open_idx(int'(idx));
        wr_req   = req_valid && req_write && in_range;
        allowed  = is_open ||
                   (lock_st != LK_HARD && (is_prot || lock_st == LK_OPEN));
        store_we = wr_req && allowed && !is_prot;
        lock_we  = wr_req && allowed && is_prot;
        blocked  = wr_req && !allowed;

        if (!in_range)    rd_val = 32'h0;
        else if (is_prot) rd_val = lock_code;
        else if (is_conf) rd_val = {store_rd[31:2], strap_size};
        else              rd_val = store_rd;

        st_d.valid   = req_valid;
        st_d.blocked = blocked;
        st_d.rdata   = (req_valid && !req_write) ? rd_val : 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready  = 1'b1;
    assign rsp_valid  = st_q.valid;
    assign rsp_rdata  = st_q.rdata;
    assign wr_blocked = st_q.blocked;

    // R4
    soft_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && in_range && !is_open && !is_prot &&
         lock_st == LK_SOFT) |=> wr_blocked);

    // R9
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !in_range) |=> (rsp_rdata == 32'h0));

    // R9
    oob_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !in_range) |=> !wr_blocked);

    // R10
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6
    conf_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && is_conf) |=>
            (rsp_rdata[31:28] == 4'd3 && rsp_rdata[18:14] == 5'd0 &&
             rsp_rdata[3:2] == 2'b11 && rsp_rdata[1:0] == $past(strap_size)));

    // R11
    read_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !wr_blocked);

endmodule

// File: tb/sim_kp_ctrl_regbank.sv
module sim_kp_ctrl_regbank;

    localparam int ADDR_W = 12;
    localparam int WORDS  = 512;
    localparam int WIN    = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        strap_size = 2'd2;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_ready, rsp_valid, wr_blocked;
    logic [31:0]       rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] mdl [WORDS];
    logic [31:0] mlock;

    always #5 clk = ~clk;

    kp_ctrl_regbank #(.ADDR_W(ADDR_W), .REG_WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .strap_size(strap_size),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .wr_blocked(wr_blocked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit open_ix(input int i);
        return (i == 20 || i == 27 || i == 29 || i == 30 || i == 31 ||
                i == 34 || i == 35 || i == 45);
    endfunction

    function automatic logic [31:0] shape(input int i, input logic [31:0] d);
        if (i == 1)  return (d & 32'h0FF03FB0) | 32'h3000000C;
        if (i == 24) return (d & ~32'h1) | 32'h10;
        if (i == 28) return (d | 32'h1000) & ~32'h2000;
        return d;
    endfunction

    function automatic string tag_of(input int i);
        if (i >= WORDS) return "R9";
        if (i == 0)     return "R1";
        if (i == 1)     return "R6";
        if (i == 24)    return "R7";
        if (i == 28)    return "R8";
        if (open_ix(i)) return "R5";
        return "R12";
    endfunction

    function automatic logic [31:0] exp_read(input int i);
        if (i >= WORDS) return 32'h0;
        if (i == 0)     return mlock;
        if (i == 1)     return mdl[1] | {30'h0, strap_size};
        return mdl[i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < WORDS; i++) mdl[i] = 32'h0;
        mdl[1]     = 32'h3000000C;
        mdl[12'h100] = 32'h2;
        mdl[12'h114] = 32'h0FFFFFFF;
        mdl[12'h11A] = 32'hFF;
        mdl[12'h11F] = 32'hFF;
        mlock = 32'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic access(input logic wr, input logic [ADDR_W-1:0] addr,
                          input logic [31:0] d, output logic [31:0] rd,
                          output logic blk);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = d;
        @(posedge clk);
        #1;
        rd  = rsp_rdata;
        blk = wr_blocked;
        // R10: response in the cycle after the request
        chk("R10", {31'h0, rsp_valid & req_ready}, 32'h1);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr_chk(input int i, input logic [31:0] d);
        logic [31:0] rd;
        logic        blk, eb;
        eb = 1'b0;
        if (i >= WORDS) eb = 1'b0;
        else if (open_ix(i)) mdl[i] = d;
        else if (mlock == 32'h10) eb = 1'b1;
        else if (i == 0)
            mlock = (d == 32'hFC600309) ? 32'h1 :
                    (d == 32'hDEADDEAD) ? 32'h10 : 32'h0;
        else if (mlock == 32'h0) eb = 1'b1;
        else mdl[i] = shape(i, d);
        access(1'b1, ADDR_W'(i * 4), d, rd, blk);
        // R11: blocked flag matches the lock rules
        chk(eb ? "R11" : tag_of(i), {31'h0, blk}, {31'h0, eb});
    endtask

    task automatic rd_chk(input int i, input string tag);
        logic [31:0] rd;
        logic        blk;
        access(1'b0, ADDR_W'(i * 4), 32'h0, rd, blk);
        chk(tag, rd, exp_read(i));
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < WORDS; i++)
            rd_chk(i, (tag == "") ? tag_of(i) : tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        blk;
        do_reset();
        // R2: reset image of the whole bank
        read_all("R2");
        idle();
        @(posedge clk); #1;
        chk("R10", {31'h0, rsp_valid}, 32'h0);

        // R4/R5: soft-locked sweep, whitelist stores, others blocked
        for (int i = 0; i < WORDS; i++)
            wr_chk(i, 32'h5A000000 ^ (i << 8) ^ i);
        for (int i = 0; i < WORDS; i++)
            rd_chk(i, (open_ix(i) || i == 0) ? tag_of(i) : "R4");

        // R1: unlock
        wr_chk(0, 32'hFC600309);
        rd_chk(0, "R1");

        // R6/R7/R8/R12: open sweep with transforms
        for (int i = 1; i < WORDS; i++)
            wr_chk(i, ~(i * 32'h00010001) ^ 32'h3C3C0000);
        read_all("");
        wr_chk(1, 32'hFFFFFFFF); rd_chk(1, "R6");
        wr_chk(1, 32'h0);        rd_chk(1, "R6");
        wr_chk(24, 32'hFFFFFFFF); rd_chk(24, "R7");
        wr_chk(24, 32'h0);        rd_chk(24, "R7");
        wr_chk(28, 32'hFFFFFFFF); rd_chk(28, "R8");
        wr_chk(28, 32'h0);        rd_chk(28, "R8");

        // R9: beyond the implemented array
        for (int i = WORDS; i < WIN; i += 7) begin
            wr_chk(i, 32'hFFFFFFFF);
            rd_chk(i, "R9");
        end
        read_all("R9");

        // R12: address bits 1:0 ignored
        access(1'b1, ADDR_W'(64 * 4 + 3), 32'hC0FFEE11, rd, blk);
        mdl[64] = 32'hC0FFEE11;
        access(1'b0, ADDR_W'(64 * 4 + 1), 32'h0, rd, blk);
        chk("R12", rd, 32'hC0FFEE11);

        // R2/R6: size bits follow the strap
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            strap_size = 2'(s);
            rd_chk(1, "R2");
        end

        // R1/R4: relock softly, then unlock again
        wr_chk(0, 32'h12345678); rd_chk(0, "R1");
        wr_chk(5, 32'hAAAA5555); rd_chk(5, "R4");
        wr_chk(0, 32'hFC600309); rd_chk(0, "R1");

        // R3: hard lock is sticky
        wr_chk(0, 32'hDEADDEAD); rd_chk(0, "R1");
        wr_chk(0, 32'hFC600309); rd_chk(0, "R3");
        wr_chk(0, 32'h11111111); rd_chk(0, "R3");
        wr_chk(1, 32'h0000FF00); rd_chk(1, "R3");
        wr_chk(6, 32'h0000FF00); rd_chk(6, "R3");
        for (int i = 0; i < 64; i++)
            if (open_ix(i)) begin
                wr_chk(i, 32'h600D0000 | i);
                rd_chk(i, "R5");
            end

        // R3: only reset leaves hard lock
        do_reset();
        rd_chk(0, "R3");
        read_all("R2");
        idle();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule